// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Layer

This block sits between the bit-level engine of a single-wire bus slave and its memory-function layer. After every bus reset it gathers an 8-bit command from the master, least significant bit first, one bit per time slot. It then runs the network-addressing command that byte selects, using a fixed 64-bit device identity held as a parameter. Some of these commands stream the identity out. Some compare a master-supplied identity against it. One walks the bitwise elimination used to enumerate devices on a shared line.

Two pieces of state survive between bus resets. A resume flag records that this device was the last one addressed by its identity, so it can be re-selected with a one-byte command. A speed flag records that the device runs at the fast bus speed. Only the speed flag leaves the block. When addressing succeeds, a one-cycle strobe hands the bus over to the memory-function layer. From then on, slots are ignored until the next bus reset.

The bit-level engine reports each time slot with `slot_stb`. For a write slot, `slot_bit` carries the level the master wrote. For a read slot it carries the sampled line, and this block does not use it. Before each slot, the engine reads `tx_en` and `tx_bit` to learn whether to drive the line and with which value.

Top module: `onewr_rom_layer`

## Requirements
- R1: After `rst_n` the outputs `od_mode`, `handoff` and `tx_en` are 0, and slots are ignored until the first `bus_rst` pulse.
- R2: After a `bus_rst`, the next 8 slots form the command byte, LSB first. Recognised codes: 33h read identity, 55h match, F0h search, CCh skip, A5h resume, 3Ch fast skip, 69h fast match.
- R3: Read identity (33h) drives `tx_en`=1 for ID_W slots, with `tx_bit` = identity bit k in slot k, LSB first. It raises `handoff` after the last slot and leaves the resume flag unchanged.
- R4: Match (55h) compares the next ID_W received bits, LSB first, with the identity. A full match sets the resume flag and raises `handoff`. The first differing bit clears the resume flag and idles the device until the next `bus_rst`.
- R5: Search (F0h) repeats a triplet for each identity bit: send the bit, send its complement, then receive the master's choice. A choice unequal to the bit clears the resume flag and idles the device (`tx_en`=0) until reset. Completing all bits sets the resume flag and raises `handoff`.
- R6: Skip (CCh) raises `handoff` after its last command bit and changes neither the resume flag nor `od_mode`.
- R7: Resume (A5h) raises `handoff` only when the resume flag is set; otherwise the device idles until reset.
- R8: Fast skip (3Ch) clears the resume flag, sets `od_mode` and raises `handoff`.
- R9: Fast match (69h) behaves as match. On a full match it also sets `od_mode`. A mismatch leaves `od_mode` as it was.
- R10: A `bus_rst` with `bus_rst_long`=1 clears `od_mode`. A `bus_rst` with `bus_rst_long`=0 keeps it.
- R11: Any other command code idles the device until reset: no `tx_en` and no `handoff`.
- R12: `handoff` is a one-cycle pulse. It appears in the cycle after the clock edge that samples the completing slot.
- R13: A `bus_rst` aborts any command in progress. It drops `tx_en` in the next cycle and restarts command reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_stb | input | 1 | One-cycle marker of a completed time slot |
| slot_bit | input | 1 | Bit written by the master in that slot |
| bus_rst | input | 1 | One-cycle marker of a detected bus reset |
| bus_rst_long | input | 1 | Qualifies `bus_rst` as a standard-speed (long) reset |
| tx_en | output | 1 | Device drives the next read slot |
| tx_bit | output | 1 | Value to drive in the next read slot (1 when idle) |
| od_mode | output | 1 | Fast bus speed selected |
| handoff | output | 1 | One-cycle strobe passing control to the memory layer |

## Verification
The bench builds the block with ID_W=64, a non-symmetric identity mixing ones and zeros across every byte, and OD_EN=1. With these values all seven command codes and the full 64-bit match and search walks are reachable. So is a mismatch injected at any bit position, including the first and last. With the fast-speed commands present, the interplay of long and short resets with `od_mode` and the resume flag can be driven in random order against a bench model.

// File: rtl/onewr_pkg.sv
package onewr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CMD,
      ST_READ,
      ST_MATCH,
      ST_SB,
      ST_SC,
      ST_SD,
      ST_DONE
   } onewr_st_t;

   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_READ,
      ACT_MATCH,
      ACT_SEARCH,
      ACT_SKIP,
      ACT_RESUME,
      ACT_FSKIP,
      ACT_FMATCH
   } onewr_act_t;

   localparam logic [7:0] CODE_READ   = 8'h33;
   localparam logic [7:0] CODE_MATCH  = 8'h55;
   localparam logic [7:0] CODE_SEARCH = 8'hF0;
   localparam logic [7:0] CODE_SKIP   = 8'hCC;
   localparam logic [7:0] CODE_RESUME = 8'hA5;
   localparam logic [7:0] CODE_FSKIP  = 8'h3C;
   localparam logic [7:0] CODE_FMATCH = 8'h69;

endpackage

// File: rtl/onewr_shifter.sv
module onewr_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift,
   input  logic         din,
   output logic [W-1:0] q_next,
   output logic         last
);
   localparam int CW = (W > 1) ? $clog2(W) : 1;

   logic [W-1:0]  q;
   logic [CW-1:0] cnt;

   // LSB-first assembly: newest bit enters at the top
   assign q_next = {din, q[W-1:1]};
   assign last   = (cnt == CW'(W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q   <= '0;
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (shift) begin
         q   <= q_next;
         cnt <= last ? '0 : cnt + CW'(1);
      end
   end
endmodule

// File: rtl/onewr_decode.sv
module onewr_decode
   import onewr_pkg::*;
#(
   parameter bit OD_EN = 1'b1
) (
   input  logic [7:0] code,
   output onewr_act_t act
);
   generate
      if (OD_EN) begin : g_fast
         always_comb begin
            case (code)
               CODE_READ:   act = ACT_READ;
               CODE_MATCH:  act = ACT_MATCH;
               CODE_SEARCH: act = ACT_SEARCH;
               CODE_SKIP:   act = ACT_SKIP;
               CODE_RESUME: act = ACT_RESUME;
               CODE_FSKIP:  act = ACT_FSKIP;
               CODE_FMATCH: act = ACT_FMATCH;
               default:     act = ACT_NONE;
            endcase
         end
      end else begin : g_std
         always_comb begin
            case (code)
               CODE_READ:   act = ACT_READ;
               CODE_MATCH:  act = ACT_MATCH;
               CODE_SEARCH: act = ACT_SEARCH;
               CODE_SKIP:   act = ACT_SKIP;
               CODE_RESUME: act = ACT_RESUME;
               default:     act = ACT_NONE;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/onewr_idbit.sv
module onewr_idbit #(
   parameter int              ID_W   = 64,
   parameter logic [ID_W-1:0] ROM_ID = '0,
   localparam int             IDX_W  = $clog2(ID_W)
) (
   input  logic [IDX_W-1:0] idx,
   output logic             bit_o,
   output logic             last
);
   assign bit_o = ROM_ID[idx];
   assign last  = (idx == IDX_W'(ID_W - 1));
endmodule

// File: rtl/onewr_rom_layer.sv
module onewr_rom_layer
   import onewr_pkg::*;
#(
   parameter int              ID_W   = 64,
   parameter logic [ID_W-1:0] ROM_ID = 64'hC3A5_9617_0E4B_D228,
   parameter bit              OD_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slot_stb,
   input  logic slot_bit,
   input  logic bus_rst,
   input  logic bus_rst_long,
   output logic tx_en,
   output logic tx_bit,
   output logic od_mode,
   output logic handoff
);
   localparam int IDX_W = $clog2(ID_W);
   localparam int CMD_W = 8;

   generate
      if ((ID_W % 8) != 0 || ID_W < 8) begin : g_bad_width
         $error("ID_W must be a positive multiple of 8");
      end
   endgenerate

   onewr_st_t        st;
   logic [IDX_W-1:0] idx;
   logic             rc;
   logic             od;
   logic             fast_pend;
   logic             ho_q;

   logic [CMD_W-1:0] cmd_next;
   logic             cmd_last;
   logic             cmd_shift;
   onewr_act_t       act;
   logic             id_bit;
   logic             id_last;

   assign cmd_shift = slot_stb && !bus_rst && (st == ST_CMD);

   onewr_shifter #(.W(CMD_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (bus_rst),
      .shift  (cmd_shift),
      .din    (slot_bit),
      .q_next (cmd_next),
      .last   (cmd_last)
   );

   onewr_decode #(.OD_EN(OD_EN)) u_dec (
      .code (cmd_next),
      .act  (act)
   );

   onewr_idbit #(.ID_W(ID_W), .ROM_ID(ROM_ID)) u_id (
      .idx   (idx),
      .bit_o (id_bit),
      .last  (id_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         idx       <= '0;
         rc        <= 1'b0;
         od        <= 1'b0;
         fast_pend <= 1'b0;
         ho_q      <= 1'b0;
      end else begin
         ho_q <= 1'b0;
         if (bus_rst) begin
            st  <= ST_CMD;
            idx <= '0;
            if (bus_rst_long) od <= 1'b0;
         end else if (slot_stb) begin
            case (st)
               ST_CMD: begin
                  if (cmd_last) begin
                     idx       <= '0;
                     fast_pend <= 1'b0;
                     case (act)
                        ACT_READ:   st <= ST_READ;
                        ACT_MATCH:  st <= ST_MATCH;
                        ACT_SEARCH: st <= ST_SB;
                        ACT_FMATCH: begin
                           st        <= ST_MATCH;
                           fast_pend <= 1'b1;
                        end
                        ACT_SKIP: begin
                           st   <= ST_DONE;
                           ho_q <= 1'b1;
                        end
                        ACT_RESUME: begin
                           st   <= rc ? ST_DONE : ST_IDLE;
                           ho_q <= rc;
                        end
                        ACT_FSKIP: begin
                           rc   <= 1'b0;
                           od   <= 1'b1;
                           st   <= ST_DONE;
                           ho_q <= 1'b1;
                        end
                        default: st <= ST_IDLE;
                     endcase
                  end
               end
               ST_READ: begin
                  if (id_last) begin
                     st   <= ST_DONE;
                     ho_q <= 1'b1;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
               ST_MATCH: begin
                  if (slot_bit != id_bit) begin
                     rc <= 1'b0;
                     st <= ST_IDLE;
                  end else if (id_last) begin
                     rc   <= 1'b1;
                     if (fast_pend) od <= 1'b1;
                     st   <= ST_DONE;
                     ho_q <= 1'b1;
                  end else begin
                     idx <= idx + IDX_W'(1);
                  end
               end
               ST_SB: st <= ST_SC;
               ST_SC: st <= ST_SD;
               ST_SD: begin
                  if (slot_bit != id_bit) begin
                     rc <= 1'b0;
                     st <= ST_IDLE;
                  end else if (id_last) begin
                     rc   <= 1'b1;
                     st   <= ST_DONE;
                     ho_q <= 1'b1;
                  end else begin
                     idx <= idx + IDX_W'(1);
                     st  <= ST_SB;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      tx_en  = (st == ST_READ) || (st == ST_SB) || (st == ST_SC);
      tx_bit = 1'b1;
      if (tx_en) tx_bit = (st == ST_SC) ? ~id_bit : id_bit;
   end

   assign od_mode = od;
   assign handoff = ho_q;

endmodule

// File: rtl/onewr_rom_chk.sv
module onewr_rom_chk (
   input logic clk,
   input logic rst_n,
   input logic slot_stb,
   input logic bus_rst,
   input logic bus_rst_long,
   input logic tx_en,
   input logic od_mode,
   input logic handoff
);
   p_ho_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      handoff |=> !handoff);

   p_ho_after_slot_r12: assert property (@(posedge clk) disable iff (!rst_n)
      handoff |-> ($past(slot_stb) && !$past(bus_rst)));

   p_ho_quiet_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
      handoff |-> !tx_en);

   p_od_long_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rst && bus_rst_long) |=> !od_mode);

   p_od_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(od_mode) |-> $past(bus_rst && bus_rst_long));

   p_od_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(od_mode) |-> ($past(slot_stb) && !$past(bus_rst)));

   p_tx_abort_r13: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> !tx_en);
endmodule

bind onewr_rom_layer onewr_rom_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .slot_stb     (slot_stb),
   .bus_rst      (bus_rst),
   .bus_rst_long (bus_rst_long),
   .tx_en        (tx_en),
   .od_mode      (od_mode),
   .handoff      (handoff)
);

// File: tb/onewr_rom_layer_tb.sv
module onewr_rom_layer_tb;
   localparam int          ID_W  = 64;
   localparam logic [63:0] TB_ID = 64'hC3A5_9617_0E4B_D228;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slot_stb = 1'b0;
   logic slot_bit = 1'b0;
   logic bus_rst = 1'b0;
   logic bus_rst_long = 1'b0;
   logic tx_en, tx_bit, od_mode, handoff;

   int n_tests = 0;
   int n_fail  = 0;
   bit m_rc = 1'b0;
   bit m_od = 1'b0;

   always #5 clk = ~clk;

   onewr_rom_layer #(.ID_W(ID_W), .ROM_ID(TB_ID), .OD_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .slot_bit(slot_bit),
      .bus_rst(bus_rst), .bus_rst_long(bus_rst_long),
      .tx_en(tx_en), .tx_bit(tx_bit), .od_mode(od_mode), .handoff(handoff)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic breset(input bit long_r);
      bus_rst = 1'b1; bus_rst_long = long_r;
      @(negedge clk);
      bus_rst = 1'b0; bus_rst_long = 1'b0;
      if (long_r) m_od = 1'b0;
   endtask

   task automatic slot(input bit b, output bit te, output bit tb, output bit hs);
      te = tx_en; tb = tx_bit;
      slot_stb = 1'b1; slot_bit = b;
      @(negedge clk);
      slot_stb = 1'b0; slot_bit = 1'b0;
      hs = handoff;
   endtask

   task automatic send_byte(input logic [7:0] c, output bit hs);
      bit te, tb, h;
      hs = 1'b0;
      for (int i = 0; i < 8; i++) begin
         slot(c[i], te, tb, h);
         hs = h;
      end
   endtask

   // returns 1 if handoff was seen anywhere; bad < 0 means a clean identity
   task automatic do_match(input logic [7:0] code, input int bad, output bit hs);
      bit te, tb, h;
      send_byte(code, hs);
      for (int i = 0; i < ID_W; i++) begin
         slot(TB_ID[i] ^ (i == bad), te, tb, h);
         hs = hs | h;
      end
   endtask

   task automatic do_search(input int bad, output bit hs, output int errs);
      bit te, tb, h, dropped;
      errs = 0; dropped = 1'b0;
      send_byte(8'hF0, hs);
      for (int i = 0; i < ID_W; i++) begin
         slot(1'b1, te, tb, h);
         if (dropped ? te : !(te && tb == TB_ID[i])) errs++;
         slot(1'b1, te, tb, h);
         if (dropped ? te : !(te && tb == !TB_ID[i])) errs++;
         slot(TB_ID[i] ^ (i == bad), te, tb, h);
         hs = hs | h;
         if (i == bad) dropped = 1'b1;
      end
   endtask

   function automatic bit exp_resume(input bit rc);
      return rc;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      bit hs, te, tb;
      int errs;
      logic [63:0] got;
      int unsigned seed;
      seed = $urandom(32'd4242);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!od_mode && !handoff && !tx_en, "R1 reset outputs", {od_mode, handoff, tx_en}, 0);
      send_byte(8'hCC, hs);
      chk(!hs, "R1 slots ignored before first bus reset", hs, 0);

      // R6 R12 skip
      breset(1'b0);
      send_byte(8'hCC, hs);
      chk(hs, "R6 skip hands off", hs, 1);
      chk(!od_mode, "R6 skip keeps speed", od_mode, 0);
      @(negedge clk);
      chk(!handoff, "R12 handoff lasts one cycle", handoff, 0);

      // R7 resume without flag
      breset(1'b0);
      send_byte(8'hA5, hs);
      chk(!hs, "R7 resume with flag clear", hs, 0);
      slot(1'b1, te, tb, hs);
      chk(!te && !hs, "R7 idle after refused resume", {te, hs}, 0);

      // R3 read identity, R2 LSB-first command
      breset(1'b0);
      send_byte(8'h33, hs);
      got = '0; errs = 0;
      for (int i = 0; i < ID_W; i++) begin
         slot(1'b1, te, tb, hs);
         got[i] = tb;
         if (!te) errs++;
         if (i < ID_W - 1 && hs) errs++;
      end
      chk(got == TB_ID && errs == 0, "R3 read identity bits", got, TB_ID);
      chk(hs, "R3 handoff after last identity bit", hs, 1);

      // R4 match good then resume
      breset(1'b0);
      do_match(8'h55, -1, hs);
      chk(hs, "R4 full match hands off", hs, 1);
      breset(1'b0);
      send_byte(8'hA5, hs);
      chk(hs, "R7 resume after match", hs, 1);
      // R6 skip keeps resume flag
      breset(1'b0);
      send_byte(8'hCC, hs);
      breset(1'b0);
      send_byte(8'hA5, hs);
      chk(hs, "R6 skip keeps resume flag", hs, 1);

      // R4 mismatch at last bit clears flag
      breset(1'b0);
      do_match(8'h55, ID_W - 1, hs);
      chk(!hs, "R4 mismatch at last bit", hs, 0);
      breset(1'b0);
      send_byte(8'hA5, hs);
      chk(!hs, "R4 mismatch clears resume flag", hs, 0);

      // R5 search full walk
      breset(1'b0);
      do_search(-1, hs, errs);
      chk(errs == 0, "R5 search triplet values", errs, 0);
      chk(hs, "R5 search completion hands off", hs, 1);
      breset(1'b0);
      send_byte(8'hA5, hs);
      chk(hs, "R5 search sets resume flag", hs, 1);
      // R5 search drop-out at random bit
      breset(1'b0);
      do_search(int'($urandom % ID_W), hs, errs);
      chk(errs == 0 && !hs, "R5 search drop-out", {errs[7:0], 7'd0, hs}, 0);
      breset(1'b0);
      send_byte(8'hA5, hs);
      chk(!hs, "R5 drop-out clears resume flag", hs, 0);

      // R8 fast skip
      breset(1'b0);
      do_match(8'h55, -1, hs);
      breset(1'b0);
      send_byte(8'h3C, hs);
      chk(hs && od_mode, "R8 fast skip hands off and sets speed", {hs, od_mode}, 2'b11);
      breset(1'b0);
      chk(od_mode, "R10 short reset keeps speed", od_mode, 1);
      send_byte(8'hA5, hs);
      chk(!hs, "R8 fast skip clears resume flag", hs, 0);
      breset(1'b1);
      chk(!od_mode, "R10 long reset clears speed", od_mode, 0);

      // R9 fast match
      breset(1'b0);
      do_match(8'h69, -1, hs);
      chk(hs && od_mode, "R9 fast match sets speed", {hs, od_mode}, 2'b11);
      breset(1'b0);
      do_match(8'h69, 0, hs);
      chk(!hs && od_mode, "R9 fast mismatch keeps speed", {hs, od_mode}, 2'b01);
      breset(1'b1);
      do_match(8'h69, 17, hs);
      chk(!hs && !od_mode, "R9 fast mismatch leaves speed clear", {hs, od_mode}, 0);

      // R11 unknown code
      breset(1'b0);
      send_byte(8'h12, hs);
      errs = 0;
      for (int i = 0; i < 16; i++) begin
         slot(i[0], te, tb, hs);
         if (te || hs) errs++;
      end
      chk(errs == 0, "R11 unknown code idles", errs, 0);

      // R13 abort mid-read
      breset(1'b0);
      send_byte(8'h33, hs);
      for (int i = 0; i < 10; i++) slot(1'b1, te, tb, hs);
      breset(1'b0);
      chk(!tx_en, "R13 reset drops transmit", tx_en, 0);
      send_byte(8'hCC, hs);
      chk(hs, "R13 command restart after abort", hs, 1);

      // random sequence against the bench model (R2 R4 R6 R7 R8 R9 R10)
      m_rc = 1'b0; m_od = 1'b0;
      breset(1'b1);
      for (int it = 0; it < 60; it++) begin
         int op;
         bit exp_hs;
         op = int'($urandom % 7);
         breset(op == 6);
         case (op)
            0: begin do_match(8'h55, -1, hs); exp_hs = 1'b1; m_rc = 1'b1; end
            1: begin do_match(8'h55, int'($urandom % ID_W), hs); exp_hs = 1'b0; m_rc = 1'b0; end
            2: begin send_byte(8'hA5, hs); exp_hs = exp_resume(m_rc); end
            3: begin send_byte(8'hCC, hs); exp_hs = 1'b1; end
            4: begin send_byte(8'h3C, hs); exp_hs = 1'b1; m_rc = 1'b0; m_od = 1'b1; end
            5: begin do_match(8'h69, -1, hs); exp_hs = 1'b1; m_rc = 1'b1; m_od = 1'b1; end
            default: begin send_byte(8'hCC, hs); exp_hs = 1'b1; end
         endcase
         chk(hs == exp_hs && od_mode == m_od, "R7 R10 random sequence",
             {hs, od_mode}, {exp_hs, m_od});
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule